// File: doc/BRIEF.md
# Single-Bit Boolean Execution Unit

This unit carries out the one-bit instructions of a small 8-bit processor. The carry flag (bit 0 of the status byte) acts as a one-bit accumulator. AND, OR and XOR fold a chosen bit of an operand into carry. Set and clear force a chosen bit of an operand to 1 or 0. Three short forms set, clear or invert carry directly. The operand can be carry itself, a short direct address, a special-function register, the accumulator, the status byte, or memory through a pointer. The pointer address and the short-direct or register address come in on one address input.

A decoder pulses `start` with the operation code, the operand space, the bit index, the address and a flag that says whether the target lies in fast internal RAM. The unit also samples the current accumulator and status byte. It stays busy for the exact instruction clock count of that combination and raises `done` in its last busy cycle. In that cycle it presents any register write-back. Memory operands use a byte bus with one cycle of read latency. The bus read comes in the first busy cycle. For set and clear, the bus write of the modified byte comes in the third busy cycle. The unit reports the instruction length so that a fetch stage can advance its program counter.

Top module: `bitop_unit`

## Requirements
- R1: AND (op 0), OR (op 1) and XOR (op 2) replace carry (status bit 0) with carry combined with the indexed operand bit. The status write carries bits 7..1 unchanged, and the accumulator and memory stay untouched.
- R2: Set (op 3) and clear (op 4) change only the indexed bit of the target. Memory targets are short direct (space 1), register (space 2) and pointer (space 5). For these the unit reads the byte, changes one bit and writes the byte back. Accumulator targets (space 3) go out through the accumulator write port.
- R3: With space 0 (carry), set makes carry 1 and clear makes it 0. Invert (op 5) complements carry. Each of these takes 2 clocks and is 1 byte long.
- R4: Set or clear on a status-byte bit (space 4) writes the whole modified byte to the status register. The zero flag (bit 6), the auxiliary carry (bit 4) and carry (bit 0) therefore take the values that write leaves.
- R5: Logic-op clock counts are as follows. Accumulator: 4. Short direct or pointer: 6 in fast RAM, 7 otherwise. Register or status byte: 7 regardless of the region flag.
- R6: Set/clear clock counts are as follows. Accumulator: 4. Status byte: 6. Register: 8. Short direct: 4 in fast RAM, 6 otherwise. Pointer: 6 in fast RAM, 8 otherwise.
- R7: Busy is high for exactly the instruction clock count after an accepted start. Done is a one-cycle pulse in the final busy cycle. After reset the unit is idle, with no bus or register write activity.
- R8: A start pulse while busy is ignored. The running instruction keeps its count, target and result.
- R9: An illegal op/space combination is ignored. These are: a logic op on carry, invert on anything but carry, op codes 6 and 7, and space codes 6 and 7.
- R10: The length output gives the instruction length in bytes. It is 3 for logic ops on short direct, register and status-byte bits, and for set/clear on register bits. It is 2 for the remaining logic, set and clear forms, and 1 for the carry forms.
- R11: Memory operands issue exactly one bus read, in the first busy cycle. Set/clear on memory issues exactly one bus write, two cycles after the read. Other operands use no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction when idle |
| op | input | 3 | Operation: 0 AND, 1 OR, 2 XOR, 3 set, 4 clear, 5 invert carry |
| space | input | 3 | Operand space: 0 carry, 1 short direct, 2 register, 3 accumulator, 4 status, 5 pointer |
| bit_sel | input | 3 | Bit index within the operand byte |
| fast_ram | input | 1 | Target lies in fast internal RAM |
| addr | input | 16 | Memory or register address of the operand |
| acc_in | input | 8 | Current accumulator |
| psw_in | input | 8 | Current status byte, carry in bit 0 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the instruction |
| instr_len | output | 2 | Instruction length in bytes |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Bus read strobe, data one cycle later |
| bus_wr | output | 1 | Bus write strobe |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| acc_we | output | 1 | Accumulator write enable |
| acc_wdata | output | 8 | Accumulator write data |
| psw_we | output | 1 | Status byte write enable |
| psw_wdata | output | 8 | Status byte write data |

## Verification
The hardest case to reach from the ports is a second start that lands in the middle of a long read-modify-write. The unit must neither restart its count nor pick up the new operation. The stimulus starts an 8-clock register set and pulses an invert-carry start in its third busy cycle. It then checks that the cycle count, the memory byte and the unchanged carry all belong to the first instruction. Every op, space and region pair is walked from a vector table with varying data, so that each timing entry and each bit position is exercised.

// File: rtl/bbu_pkg.sv
package bbu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_SET = 3'd3,
    OP_CLR = 3'd4,
    OP_NOT = 3'd5
  } bop_e;

  typedef enum logic [2:0] {
    SP_CY  = 3'd0,
    SP_DIR = 3'd1,
    SP_SFR = 3'd2,
    SP_ACC = 3'd3,
    SP_PSW = 3'd4,
    SP_IND = 3'd5
  } bsp_e;

  // carry lives in bit 0 of the status byte
  localparam int CY_POS = 0;

  function automatic logic is_logic(input bop_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
  endfunction

  function automatic logic is_force(input bop_e o);
    return (o == OP_SET) || (o == OP_CLR);
  endfunction

  function automatic logic is_mem(input bsp_e s);
    return (s == SP_DIR) || (s == SP_SFR) || (s == SP_IND);
  endfunction

endpackage

// File: rtl/bbu_cost.sv
module bbu_cost
  import bbu_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  bop_e             op,
  input  bsp_e             sp,
  input  logic             fast,
  output logic             legal,
  output logic [CNT_W-1:0] cycles,
  output logic [1:0]       ilen
);

  always_comb begin
    legal  = 1'b0;
    cycles = CNT_W'(2);
    ilen   = 2'd1;
    case (op)
      OP_AND, OP_OR, OP_XOR: begin
        legal = 1'b1;
        case (sp)
          SP_ACC: begin cycles = CNT_W'(4); ilen = 2'd2; end
          SP_DIR: begin cycles = fast ? CNT_W'(6) : CNT_W'(7); ilen = 2'd3; end
          SP_IND: begin cycles = fast ? CNT_W'(6) : CNT_W'(7); ilen = 2'd2; end
          SP_SFR: begin cycles = CNT_W'(7); ilen = 2'd3; end
          SP_PSW: begin cycles = CNT_W'(7); ilen = 2'd3; end
          default: legal = 1'b0;
        endcase
      end
      OP_SET, OP_CLR: begin
        legal = 1'b1;
        case (sp)
          SP_CY:  begin cycles = CNT_W'(2); ilen = 2'd1; end
          SP_ACC: begin cycles = CNT_W'(4); ilen = 2'd2; end
          SP_PSW: begin cycles = CNT_W'(6); ilen = 2'd2; end
          SP_SFR: begin cycles = CNT_W'(8); ilen = 2'd3; end
          SP_DIR: begin cycles = fast ? CNT_W'(4) : CNT_W'(6); ilen = 2'd2; end
          SP_IND: begin cycles = fast ? CNT_W'(6) : CNT_W'(8); ilen = 2'd2; end
          default: legal = 1'b0;
        endcase
      end
      OP_NOT: begin
        legal  = (sp == SP_CY);
        cycles = CNT_W'(2);
        ilen   = 2'd1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/bbu_seq.sv
module bbu_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] cycles,
  output logic             busy,
  output logic [CNT_W-1:0] ph,
  output logic             last
);

  logic [CNT_W-1:0] n_q;

  assign last = busy && (ph == n_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      n_q  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      ph   <= '0;
      n_q  <= cycles;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        ph   <= '0;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end

  // R7: busy holds until the counted end, and ends only there
  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);
  assert_end_at_last_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(last));
  assert_phase_range_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (ph < n_q));

endmodule

// File: rtl/bbu_alu.sv
module bbu_alu
  import bbu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  bop_e              op,
  input  bsp_e              sp,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] psw,
  input  logic [DATA_W-1:0] mem,
  output logic              new_cy,
  output logic [DATA_W-1:0] new_byte
);

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] src;
  logic              bit_v;
  logic              cy;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx == IDX_W'(g));
  end

  assign cy = psw[CY_POS];

  always_comb begin
    case (sp)
      SP_ACC:  src = acc;
      SP_PSW:  src = psw;
      SP_CY:   src = {{(DATA_W-1){1'b0}}, cy};
      default: src = mem;
    endcase
  end

  assign bit_v = |(src & mask);

  always_comb begin
    new_cy   = cy;
    new_byte = src;
    case (op)
      OP_AND: new_cy = cy & bit_v;
      OP_OR:  new_cy = cy | bit_v;
      OP_XOR: new_cy = cy ^ bit_v;
      OP_SET: begin
        new_byte = src | mask;
        new_cy   = (sp == SP_CY) ? 1'b1 : cy;
      end
      OP_CLR: begin
        new_byte = src & ~mask;
        new_cy   = (sp == SP_CY) ? 1'b0 : cy;
      end
      OP_NOT: new_cy = ~cy;
      default: new_cy = cy;
    endcase
  end

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bbu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [2:0]        space,
  input  logic [IDX_W-1:0]  bit_sel,
  input  logic              fast_ram,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] psw_in,
  output logic              busy,
  output logic              done,
  output logic [1:0]        instr_len,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_wdata,
  output logic              psw_we,
  output logic [DATA_W-1:0] psw_wdata
);

  localparam logic [CNT_W-1:0] PH_RD  = CNT_W'(0);
  localparam logic [CNT_W-1:0] PH_CAP = CNT_W'(1);
  localparam logic [CNT_W-1:0] PH_WR  = CNT_W'(2);

  bop_e              op_in, op_q;
  bsp_e              sp_in, sp_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] acc_q, psw_q, mem_q;
  logic              legal, go, last, new_cy;
  logic [CNT_W-1:0]  cyc, ph;
  logic [1:0]        len_c;
  logic [DATA_W-1:0] new_byte;

  assign op_in = bop_e'(op);
  assign sp_in = bsp_e'(space);

  bbu_cost #(.CNT_W(CNT_W)) u_cost (
    .op(op_in), .sp(sp_in), .fast(fast_ram),
    .legal(legal), .cycles(cyc), .ilen(len_c)
  );

  assign go = start && !busy && legal;

  bbu_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .cycles(cyc),
    .busy(busy), .ph(ph), .last(last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q      <= OP_AND;
      sp_q      <= SP_CY;
      idx_q     <= '0;
      addr_q    <= '0;
      acc_q     <= '0;
      psw_q     <= '0;
      instr_len <= '0;
    end else if (go) begin
      op_q      <= op_in;
      sp_q      <= sp_in;
      idx_q     <= bit_sel;
      addr_q    <= addr;
      acc_q     <= acc_in;
      psw_q     <= psw_in;
      instr_len <= len_c;
    end
  end

  // read data arrives one cycle after the strobe
  always_ff @(posedge clk) begin
    if (rst)                      mem_q <= '0;
    else if (busy && ph == PH_CAP) mem_q <= bus_rdata;
  end

  bbu_alu #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_alu (
    .op(op_q), .sp(sp_q), .idx(idx_q),
    .acc(acc_q), .psw(psw_q), .mem(mem_q),
    .new_cy(new_cy), .new_byte(new_byte)
  );

  assign done      = last;
  assign bus_addr  = addr_q;
  assign bus_rd    = busy && is_mem(sp_q) && (ph == PH_RD);
  assign bus_wr    = busy && is_mem(sp_q) && is_force(op_q) && (ph == PH_WR);
  assign bus_wdata = new_byte;

  assign acc_we    = done && is_force(op_q) && (sp_q == SP_ACC);
  assign acc_wdata = new_byte;

  always_comb begin
    psw_we    = done && (is_logic(op_q) || (op_q == OP_NOT) ||
                         (sp_q == SP_CY) || (sp_q == SP_PSW));
    psw_wdata = psw_q;
    if (is_force(op_q) && sp_q == SP_PSW) psw_wdata = new_byte;
    else psw_wdata[CY_POS] = new_cy;
  end

  // R7: done is one cycle and closes the busy window
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R8: a start in mid-instruction leaves the latched instruction alone
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(instr_len) && $stable(bus_addr)));
  // R9: illegal combinations never begin an instruction
  assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !legal) |=> !busy);
  // R11: the write-back trails the read by two cycles, one read per op
  assert_wr_after_rd_R11: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $past(bus_rd, 2));
  assert_single_rd_R11: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);
  // R2: register write-backs happen only as the instruction closes
  assert_we_closing_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_we || psw_we) |=> !busy);

endmodule

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0, space = '0, bit_sel = '0;
  logic        fast_ram = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  acc_m = '0, psw_m = '0;
  logic        busy, done, bus_rd, bus_wr, acc_we, psw_we;
  logic [1:0]  instr_len;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, acc_wdata, psw_wdata;
  logic [7:0]  bus_rdata = '0;
  logic [7:0]  mem [256];

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  bitop_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .space(space),
    .bit_sel(bit_sel), .fast_ram(fast_ram), .addr(addr),
    .acc_in(acc_m), .psw_in(psw_m), .busy(busy), .done(done),
    .instr_len(instr_len), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .acc_we(acc_we), .acc_wdata(acc_wdata), .psw_we(psw_we),
    .psw_wdata(psw_wdata)
  );

  // byte memory with one cycle read latency, and the CPU registers
  always @(posedge clk) begin
    if (bus_wr) mem[bus_addr[7:0]] <= bus_wdata;
    if (bus_rd) bus_rdata <= mem[bus_addr[7:0]];
    if (acc_we) acc_m <= acc_wdata;
    if (psw_we) psw_m <= psw_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {op[15:13], space[12:10], fast[9], idx[8:6], cycles[5:2], len[1:0]}
  localparam int NV = 38;
  localparam logic [15:0] VEC [NV] = '{
    {3'd0,3'd3,1'b0,3'd0,4'd4,2'd2}, {3'd0,3'd1,1'b1,3'd1,4'd6,2'd3},
    {3'd0,3'd1,1'b0,3'd2,4'd7,2'd3}, {3'd0,3'd5,1'b1,3'd3,4'd6,2'd2},
    {3'd0,3'd5,1'b0,3'd4,4'd7,2'd2}, {3'd0,3'd2,1'b1,3'd5,4'd7,2'd3},
    {3'd0,3'd4,1'b0,3'd6,4'd7,2'd3},
    {3'd1,3'd3,1'b1,3'd7,4'd4,2'd2}, {3'd1,3'd1,1'b1,3'd0,4'd6,2'd3},
    {3'd1,3'd1,1'b0,3'd1,4'd7,2'd3}, {3'd1,3'd5,1'b1,3'd2,4'd6,2'd2},
    {3'd1,3'd5,1'b0,3'd3,4'd7,2'd2}, {3'd1,3'd2,1'b0,3'd4,4'd7,2'd3},
    {3'd1,3'd4,1'b1,3'd5,4'd7,2'd3},
    {3'd2,3'd3,1'b0,3'd6,4'd4,2'd2}, {3'd2,3'd1,1'b1,3'd7,4'd6,2'd3},
    {3'd2,3'd1,1'b0,3'd0,4'd7,2'd3}, {3'd2,3'd5,1'b1,3'd1,4'd6,2'd2},
    {3'd2,3'd5,1'b0,3'd2,4'd7,2'd2}, {3'd2,3'd2,1'b1,3'd3,4'd7,2'd3},
    {3'd2,3'd4,1'b0,3'd4,4'd7,2'd3},
    {3'd3,3'd3,1'b1,3'd5,4'd4,2'd2}, {3'd3,3'd4,1'b0,3'd6,4'd6,2'd2},
    {3'd3,3'd2,1'b0,3'd7,4'd8,2'd3}, {3'd3,3'd1,1'b1,3'd0,4'd4,2'd2},
    {3'd3,3'd1,1'b0,3'd1,4'd6,2'd2}, {3'd3,3'd5,1'b1,3'd2,4'd6,2'd2},
    {3'd3,3'd5,1'b0,3'd3,4'd8,2'd2}, {3'd3,3'd0,1'b0,3'd0,4'd2,2'd1},
    {3'd4,3'd3,1'b0,3'd4,4'd4,2'd2}, {3'd4,3'd4,1'b0,3'd0,4'd6,2'd2},
    {3'd4,3'd2,1'b1,3'd5,4'd8,2'd3}, {3'd4,3'd1,1'b1,3'd6,4'd4,2'd2},
    {3'd4,3'd1,1'b0,3'd7,4'd6,2'd2}, {3'd4,3'd5,1'b1,3'd0,4'd6,2'd2},
    {3'd4,3'd5,1'b0,3'd1,4'd8,2'd2}, {3'd4,3'd0,1'b0,3'd0,4'd2,2'd1},
    {3'd5,3'd0,1'b0,3'd0,4'd2,2'd1}
  };

  task automatic run_op(input logic [2:0] o, input logic [2:0] s, input logic f,
                        input logic [2:0] ix, input int ecyc, input int elen,
                        input logic [7:0] a, input bit intrude);
    logic [7:0] pa, pp, pm, src, eacc, epsw, emem;
    logic b, ecy;
    int cnt, dcnt, dpos, rdc, wrc, lens;
    bit memsp;
    pa = acc_m; pp = psw_m; pm = mem[a];
    memsp = (s == 3'd1) || (s == 3'd2) || (s == 3'd5);
    src = (s == 3'd3) ? pa : (s == 3'd4) ? pp : (s == 3'd0) ? {7'd0, pp[0]} : pm;
    b = src[ix];
    eacc = pa; epsw = pp; emem = pm;
    case (o)
      3'd0: ecy = pp[0] & b;
      3'd1: ecy = pp[0] | b;
      3'd2: ecy = pp[0] ^ b;
      3'd5: ecy = ~pp[0];
      default: ecy = pp[0];
    endcase
    if (o <= 3'd2 || o == 3'd5) epsw[0] = ecy;
    if (o == 3'd3 || o == 3'd4) begin
      logic [7:0] nb;
      nb = src;
      nb[ix] = (o == 3'd3);
      if (s == 3'd0) epsw[0] = (o == 3'd3);
      else if (s == 3'd3) eacc = nb;
      else if (s == 3'd4) epsw = nb;
      else emem = nb;
    end
    @(negedge clk);
    op = o; space = s; fast_ram = f; bit_sel = ix; addr = {8'h00, a}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0; dcnt = 0; dpos = 0; rdc = 0; wrc = 0; lens = 0;
    while (busy && cnt < 20) begin
      cnt++;
      if (bus_rd) rdc++;
      if (bus_wr) wrc++;
      if (done) begin dcnt++; dpos = cnt; lens = instr_len; end
      if (intrude && cnt == 3) begin
        op = 3'd5; space = 3'd0; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (o == 3'd3 || o == 3'd4) begin
      if (s == 3'd0) chk(cnt == ecyc, "R3 carry-form cycles", cnt, ecyc);
      else chk(cnt == ecyc, "R6 set/clear cycles", cnt, ecyc);
    end else if (o == 3'd5) chk(cnt == ecyc, "R3 invert cycles", cnt, ecyc);
    else chk(cnt == ecyc, "R5 logic cycles", cnt, ecyc);
    chk(dcnt == 1 && dpos == ecyc, "R7 done pulse position", dpos, ecyc);
    chk(lens == elen, "R10 instruction length", lens, elen);
    chk(rdc == (memsp ? 1 : 0), "R11 bus reads", rdc, memsp ? 1 : 0);
    chk(wrc == ((memsp && (o == 3'd3 || o == 3'd4)) ? 1 : 0), "R11 bus writes",
        wrc, (memsp && (o == 3'd3 || o == 3'd4)) ? 1 : 0);
    if (o <= 3'd2) chk(psw_m == epsw, "R1 status after logic op", psw_m, epsw);
    else if (s == 3'd0) chk(psw_m == epsw, "R3 carry form", psw_m, epsw);
    else if (s == 3'd4) chk(psw_m == epsw && psw_m[6] == epsw[6] && psw_m[4] == epsw[4],
                            "R4 status byte write", psw_m, epsw);
    else chk(psw_m == epsw, "R2 status untouched", psw_m, epsw);
    chk(acc_m == eacc, (o <= 3'd2) ? "R1 accumulator untouched" : "R2 accumulator", acc_m, eacc);
    chk(mem[a] == emem, intrude ? "R8 memory of first op" : "R2 memory byte", mem[a], emem);
  endtask

  task automatic try_illegal(input logic [2:0] o, input logic [2:0] s);
    logic [7:0] pa, pp, pm;
    bit seen;
    pa = acc_m; pp = psw_m; pm = mem[8'h30];
    @(negedge clk);
    op = o; space = s; bit_sel = 3'd2; addr = 16'h0030; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (busy || bus_rd || bus_wr || psw_we || acc_we) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, "R9 illegal start stays idle", seen, 0);
    chk(psw_m == pp && acc_m == pa && mem[8'h30] == pm, "R9 state unchanged",
        psw_m, pp);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 7);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr && !psw_we && !acc_we,
        "R7 idle after reset", {busy, done, bus_rd, bus_wr, psw_we, acc_we}, 0);

    for (int i = 0; i < NV; i++) begin
      acc_m = 8'h3C ^ 8'(i * 29);
      psw_m = 8'hA5 ^ 8'(i * 53);
      mem[8'(8'h20 + i)] = 8'h96 ^ 8'(i * 71);
      run_op(VEC[i][15:13], VEC[i][12:10], VEC[i][9], VEC[i][8:6],
             int'(VEC[i][5:2]), int'(VEC[i][1:0]), 8'(8'h20 + i), 1'b0);
    end

    // R8: start an 8-clock register set, then pulse invert-carry mid-flight
    psw_m = 8'h01; mem[8'h50] = 8'h00;
    run_op(3'd3, 3'd2, 1'b0, 3'd5, 8, 3, 8'h50, 1'b1);
    chk(!busy, "R8 no restart after intruding start", busy, 0);

    // R9: illegal combinations
    try_illegal(3'd5, 3'd1);
    try_illegal(3'd0, 3'd0);
    try_illegal(3'd6, 3'd1);
    try_illegal(3'd3, 3'd7);

    // R3: back-to-back carry forms from a known carry
    psw_m = 8'hFE;
    run_op(3'd5, 3'd0, 1'b1, 3'd0, 2, 1, 8'h60, 1'b0);
    chk(psw_m == 8'hFF, "R3 invert sets carry", psw_m, 8'hFF);
    run_op(3'd4, 3'd0, 1'b0, 3'd0, 2, 1, 8'h60, 1'b0);
    chk(psw_m == 8'hFE, "R3 clear carry", psw_m, 8'hFE);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule